// File: doc/BRIEF.md
# Single-Register Load/Store Address Unit

This block takes one 32-bit single-register load/store instruction word and turns it into one access on a word-addressed memory port. It works out the offset, either a 12-bit unsigned immediate or a shifted register value, and adds it to or subtracts it from the base. It then picks the pre-indexed or post-indexed address, drives a read or a write strobe with byte lanes, and returns the value for the destination register on a load. It also reports the adjusted base for writeback into the base register.

Register-file reads happen outside the block. The base, offset-register and store-data values arrive as inputs. The block puts the decoded register indices on outputs so that the surrounding pipeline can fetch them. Condition evaluation also happens outside: the condition field goes out on `cond_code`, and the verdict comes back on `cond_ok`.

A request is presented with `start` for one cycle. The memory strobes, the address and the writeback result appear on the next cycle. Memory read data is taken during the strobe cycle, and the load result appears one cycle after that.

Top module: `ls_addr_unit`

## Requirements
- R1: When `start` is high but `cond_ok` is 0, or `instr[27:26]` is not 01, or a register offset (`instr[25]`=0) has `instr[4]`=1, the block raises no read strobe, no write strobe, no writeback and no load result.
- R2: `instr[20]`=1 makes the transfer a read (`mem_rd`). `instr[20]`=0 makes it a write (`mem_wr`). Exactly one strobe pulses, for one cycle, in the cycle after `start`.
- R3: When `instr[25]`=1 the offset is `instr[11:0]` zero-extended (0 to 4095). `instr[23]`=1 adds the offset to `base_val` and `instr[23]`=0 subtracts it.
- R4: When `instr[25]`=0 the offset is `rm_val` shifted by `instr[11:7]`, with the type taken from `instr[6:5]`: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right. An amount of 0 means 32 for logical right (result 0) and for arithmetic right (every bit equals bit 31). An amount of 0 means no rotation for rotate right.
- R5: When `instr[24]`=1 the access address is the adjusted base. When it is 0 the access address is the unmodified `base_val`. `mem_word_addr` carries address bits 31:2.
- R6: `wb_en` pulses with the strobe when `instr[21]`=1 or `instr[24]`=0. `wb_reg` is `instr[19:16]` and `wb_data` is the adjusted base.
- R7: A word store (`instr[22]`=0) drives `mem_be`=1111 and `mem_wdata`=`rd_val`.
- R8: A byte store (`instr[22]`=1) copies `rd_val[7:0]` onto all four lanes and sets `mem_be` to a one-hot value: bit n is set when address bits 1:0 equal n.
- R9: A word load raises `ld_en` one cycle after `mem_rd`, with `ld_reg`=`instr[15:12]` and `ld_data`=`mem_rdata` as sampled in the strobe cycle.
- R10: A byte load returns lane n of `mem_rdata`, zero-extended, where n is address bits 1:0 (lane 0 is bits 7:0).
- R11: After reset every strobe and enable output is 0. `rn_sel`, `rm_sel` and `cond_code` show `instr[19:16]`, `instr[3:0]` and `instr[31:28]` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction valid for one cycle |
| instr | input | 32 | Instruction word |
| cond_ok | input | 1 | External condition verdict for `instr` |
| base_val | input | 32 | Contents of the base register |
| rm_val | input | 32 | Contents of the offset register |
| rd_val | input | 32 | Store data from the data register |
| mem_rdata | input | 32 | Memory read data, valid while `mem_rd` is high |
| cond_code | output | 4 | Condition field for external evaluation |
| rn_sel | output | 4 | Base register index |
| rm_sel | output | 4 | Offset register index |
| mem_word_addr | output | 30 | Word address (byte address bits 31:2) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data |
| ld_en | output | 1 | Load result valid |
| ld_reg | output | 4 | Destination register of the load |
| ld_data | output | 32 | Load result |
| wb_en | output | 1 | Base writeback valid |
| wb_reg | output | 4 | Register to write back |
| wb_data | output | 32 | Adjusted base value |

## Verification
The hardest cases to reach from the ports are the corners of the shifted-register offset. A logical or arithmetic right shift with an encoded amount of zero must act as a shift by 32, and a rotate must bring low bits round to the top. The bench reaches these by building register-offset words with amount zero and with a nonzero rotate, using an offset register value whose top bit is set. It then picks base values so that an add of the all-ones offset wraps and lands on a known word address. A post-indexed byte load on an odd base covers both the lane selection and the writeback that happens without the W flag.

// File: rtl/ls_addr_unit.sv
module ls_addr_unit #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic          cond_ok,
  input  logic [XW-1:0] base_val,
  input  logic [XW-1:0] rm_val,
  input  logic [XW-1:0] rd_val,
  input  logic [XW-1:0] mem_rdata,
  output logic [3:0]    cond_code,
  output logic [3:0]    rn_sel,
  output logic [3:0]    rm_sel,
  output logic [XW-3:0] mem_word_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [3:0]    mem_be,
  output logic [XW-1:0] mem_wdata,
  output logic          ld_en,
  output logic [3:0]    ld_reg,
  output logic [XW-1:0] ld_data,
  output logic          wb_en,
  output logic [3:0]    wb_reg,
  output logic [XW-1:0] wb_data
);
  localparam int SW = $clog2(XW);

  wire f_imm   = instr[25];
  wire f_pre   = instr[24];
  wire f_up    = instr[23];
  wire f_byte  = instr[22];
  wire f_wback = instr[21];
  wire f_load  = instr[20];

  assign cond_code = instr[31:28];
  assign rn_sel    = instr[19:16];
  assign rm_sel    = instr[3:0];

  wire legal = (instr[27:26] == 2'b01) && (f_imm || !instr[4]);
  wire go    = start && cond_ok && legal;

  wire [SW-1:0] amt = instr[7+SW-1:7];
  logic [XW-1:0] shifted;

  always_comb begin
    case (instr[6:5])
      2'b00:   shifted = rm_val << amt;
      2'b01:   shifted = (amt == '0) ? '0 : rm_val >> amt;
      2'b10:   shifted = (amt == '0) ? {XW{rm_val[XW-1]}}
                                     : XW'($signed(rm_val) >>> amt);
      default: shifted = (amt == '0) ? rm_val
                                     : (rm_val >> amt) | (rm_val << (XW - int'(amt)));
    endcase
  end

  wire [XW-1:0] offset   = f_imm ? XW'(instr[11:0]) : shifted;
  wire [XW-1:0] adjusted = f_up ? base_val + offset : base_val - offset;
  wire [XW-1:0] addr     = f_pre ? adjusted : base_val;

  logic       byte_q;
  logic [1:0] lane_q;
  logic [3:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_word_addr <= '0;
      mem_rd        <= 1'b0;
      mem_wr        <= 1'b0;
      mem_be        <= 4'b0;
      mem_wdata     <= '0;
      wb_en         <= 1'b0;
      wb_reg        <= 4'b0;
      wb_data       <= '0;
      byte_q        <= 1'b0;
      lane_q        <= 2'b0;
      rd_q          <= 4'b0;
    end else begin
      mem_rd <= go && f_load;
      mem_wr <= go && !f_load;
      wb_en  <= go && (f_wback || !f_pre);
      if (go) begin
        mem_word_addr <= addr[XW-1:2];
        mem_be        <= f_byte ? 4'b0001 << addr[1:0] : 4'b1111;
        mem_wdata     <= f_byte ? {(XW/8){rd_val[7:0]}} : rd_val;
        wb_reg        <= instr[19:16];
        wb_data       <= adjusted;
        byte_q        <= f_byte;
        lane_q        <= addr[1:0];
        rd_q          <= instr[15:12];
      end else begin
        mem_be <= 4'b0;
      end
    end
  end

  wire [XW-1:0] lane_sh = mem_rdata >> {lane_q, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_en   <= 1'b0;
      ld_reg  <= 4'b0;
      ld_data <= '0;
    end else begin
      ld_en <= mem_rd;
      if (mem_rd) begin
        ld_reg  <= rd_q;
        ld_data <= byte_q ? XW'(lane_sh[7:0]) : mem_rdata;
      end
    end
  end
endmodule

// File: rtl/ls_addr_unit_chk.sv
module ls_addr_unit_chk #(
  parameter int XW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [31:0]   instr,
  input logic          cond_ok,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [3:0]    mem_be,
  input logic          ld_en,
  input logic          wb_en,
  input logic [3:0]    wb_reg
);
  a_r1_blocked_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (!cond_ok || instr[27:26] != 2'b01)) |=> (!mem_rd && !mem_wr && !wb_en));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> $past(start));

  a_r8_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_be == 4'b1111 || $countones(mem_be) == 1));

  a_r6_wb_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (mem_rd || mem_wr));

  a_r6_wb_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cond_ok && instr[27:26] == 2'b01 && instr[25]) |=> (wb_reg == $past(instr[19:16])));

  a_r9_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ld_en);

  a_r9_no_stray_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> $past(mem_rd));
endmodule

bind ls_addr_unit ls_addr_unit_chk #(.XW(XW)) chk_i (.*);

// File: tb/ls_addr_unit_tb_top.sv
module ls_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_ok = 1'b0;
  logic [31:0] base_val = '0, rm_val = '0, rd_val = '0, mem_rdata = '0;
  logic [3:0]  cond_code, rn_sel, rm_sel, mem_be, ld_reg, wb_reg;
  logic [29:0] mem_word_addr;
  logic        mem_rd, mem_wr, ld_en, wb_en;
  logic [31:0] mem_wdata, ld_data, wb_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ls_addr_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit i, p, u, b, w, l,
                                     input logic [3:0] rn, rd, input logic [11:0] off);
    return {4'hE, 2'b01, i, p, u, b, w, l, rn, rd, off};
  endfunction

  function automatic logic [11:0] roff(input int amt, input int typ, input int rm);
    return {amt[4:0], typ[1:0], 1'b0, rm[3:0]};
  endfunction

  task automatic issue(input logic [31:0] iw, input logic ok, input logic [31:0] b,
                       input logic [31:0] r, input logic [31:0] d, input logic [31:0] rdat);
    @(negedge clk);
    instr = iw; cond_ok = ok; base_val = b; rm_val = r; rd_val = d; mem_rdata = rdat;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 mem_rd", {31'b0, mem_rd}, 0);
    chk("R11 mem_wr", {31'b0, mem_wr}, 0);
    chk("R11 ld_en", {31'b0, ld_en}, 0);
    chk("R11 wb_en", {31'b0, wb_en}, 0);
    instr = 32'hA123_4567;
    #1;
    chk("R11 cond_code", {28'b0, cond_code}, 32'hA);
    chk("R11 rn_sel", {28'b0, rn_sel}, 32'h3);
    chk("R11 rm_sel", {28'b0, rm_sel}, 32'h7);
  endtask

  task automatic t_word_load_pre;
    issue(mk(1, 1, 1, 0, 0, 1, 4'd2, 4'd1, 12'h010), 1, 32'h1000, 0, 0, 32'hDEADBEEF);
    chk("R2 load strobe", {31'b0, mem_rd}, 1);
    chk("R2 no write", {31'b0, mem_wr}, 0);
    chk("R3 R5 addr", {2'b0, mem_word_addr}, 32'h404);
    chk("R6 no wb", {31'b0, wb_en}, 0);
    @(negedge clk);
    chk("R9 ld_en", {31'b0, ld_en}, 1);
    chk("R9 ld_reg", {28'b0, ld_reg}, 1);
    chk("R9 ld_data", ld_data, 32'hDEADBEEF);
    chk("R2 pulse", {31'b0, mem_rd}, 0);
  endtask

  task automatic t_word_store_sub_wb;
    issue(mk(1, 1, 0, 0, 1, 0, 4'd13, 4'd5, 12'h004), 1, 32'h2000, 0, 32'hCAFE_F00D, 0);
    chk("R2 store strobe", {31'b0, mem_wr}, 1);
    chk("R3 sub addr", {2'b0, mem_word_addr}, 32'h7FF);
    chk("R7 be", {28'b0, mem_be}, 32'hF);
    chk("R7 wdata", mem_wdata, 32'hCAFE_F00D);
    chk("R6 wb_en", {31'b0, wb_en}, 1);
    chk("R6 wb_reg", {28'b0, wb_reg}, 13);
    chk("R6 wb_data", wb_data, 32'h1FFC);
    @(negedge clk);
    chk("R9 no ld after store", {31'b0, ld_en}, 0);
  endtask

  task automatic t_byte_load_post;
    issue(mk(1, 0, 1, 1, 0, 1, 4'd4, 4'd6, 12'h008), 1, 32'h3001, 0, 0, 32'h1122_3344);
    chk("R5 post addr", {2'b0, mem_word_addr}, 32'hC00);
    chk("R6 post wb_en", {31'b0, wb_en}, 1);
    chk("R6 post wb_data", wb_data, 32'h3009);
    @(negedge clk);
    chk("R10 byte lane1", ld_data, 32'h0000_0033);
    chk("R10 ld_reg", {28'b0, ld_reg}, 6);
  endtask

  task automatic t_byte_store_lane3;
    issue(mk(1, 1, 1, 1, 0, 0, 4'd0, 4'd2, 12'h000), 1, 32'h4003, 0, 32'h1234_56AB, 0);
    chk("R8 be lane3", {28'b0, mem_be}, 32'h8);
    chk("R8 replicated", mem_wdata, 32'hABAB_ABAB);
    chk("R8 addr", {2'b0, mem_word_addr}, 32'h1000);
  endtask

  task automatic t_imm_max_byte_load;
    issue(mk(1, 1, 1, 1, 0, 1, 4'd0, 4'd3, 12'hFFF), 1, 32'h0, 0, 0, 32'hA1B2_C3D4);
    chk("R3 imm 4095 addr", {2'b0, mem_word_addr}, 32'h3FF);
    chk("R8 be on byte load", {28'b0, mem_be}, 32'h8);
    @(negedge clk);
    chk("R10 byte lane3", ld_data, 32'h0000_00A1);
  endtask

  task automatic t_reg_lsl;
    issue(mk(0, 1, 1, 0, 0, 1, 4'd1, 4'd0, roff(2, 0, 1)), 1, 32'h100, 32'd3, 0, 0);
    chk("R4 lsl2 addr", {2'b0, mem_word_addr}, 32'h43);
  endtask

  task automatic t_reg_lsr0;
    issue(mk(0, 1, 1, 0, 1, 1, 4'd1, 4'd0, roff(0, 1, 1)), 1, 32'h200, 32'hFFFF, 0, 0);
    chk("R4 lsr#0 is zero", wb_data, 32'h200);
  endtask

  task automatic t_reg_asr0;
    issue(mk(0, 1, 1, 0, 1, 1, 4'd1, 4'd0, roff(0, 2, 1)), 1, 32'h104, 32'h8000_0000, 0, 0);
    chk("R4 asr#0 sign fill", wb_data, 32'h103);
    chk("R4 asr#0 addr", {2'b0, mem_word_addr}, 32'h40);
  endtask

  task automatic t_reg_asr4;
    issue(mk(0, 1, 0, 0, 1, 1, 4'd1, 4'd0, roff(4, 2, 1)), 1, 32'hF800_0008, 32'h8000_0040, 0, 0);
    chk("R4 asr#4", wb_data, 32'h4);
  endtask

  task automatic t_reg_ror;
    issue(mk(0, 1, 0, 0, 1, 1, 4'd1, 4'd0, roff(8, 3, 1)), 1, 32'hF000_0010, 32'h0000_00F0, 0, 0);
    chk("R4 ror#8", wb_data, 32'h10);
    issue(mk(0, 1, 1, 0, 1, 1, 4'd1, 4'd0, roff(0, 3, 1)), 1, 32'h10, 32'h0000_0005, 0, 0);
    chk("R4 ror#0 unchanged", wb_data, 32'h15);
  endtask

  task automatic t_blocked;
    issue(mk(1, 0, 1, 0, 1, 1, 4'd1, 4'd0, 12'h4), 0, 32'h500, 0, 0, 0);
    chk("R1 cond fail rd", {31'b0, mem_rd}, 0);
    chk("R1 cond fail wb", {31'b0, wb_en}, 0);
    @(negedge clk);
    chk("R1 cond fail ld", {31'b0, ld_en}, 0);
    issue({4'hE, 2'b00, 26'h3FF_FFFF}, 1, 32'h500, 0, 0, 0);
    chk("R1 wrong class rd", {31'b0, mem_rd}, 0);
    chk("R1 wrong class wr", {31'b0, mem_wr}, 0);
    issue(mk(0, 1, 1, 0, 1, 0, 4'd1, 4'd0, 12'h010), 1, 32'h500, 0, 0, 0);
    chk("R1 reg-shift form wr", {31'b0, mem_wr}, 0);
    chk("R1 reg-shift form wb", {31'b0, wb_en}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_word_load_pre;
    t_word_store_sub_wb;
    t_byte_load_post;
    t_byte_store_lane3;
    t_imm_max_byte_load;
    t_reg_lsl;
    t_reg_lsr0;
    t_reg_asr0;
    t_reg_asr4;
    t_reg_ror;
    t_blocked;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule